// File: doc/BRIEF.md
# Programmable Clock Divider with Stop

This block derives one output clock from a set of source clocks. A single 32-bit control register, written and read from a register clock domain, holds three things. The first is an integer divide ratio from 1 to 64. The second is a stop control that holds the output low. The third, when the block has several sources, is a field that picks the source clock. The number of sources is fixed at elaboration to 1, 4 or 8, and that number decides where the source field sits in the register.

Any change of divisor, source or stop state is applied without a runt pulse on the output:

- Source switching uses a break-before-make handshake. Each source enable is synchronised in its own clock domain and changes only while that source is low.
- A new divisor or stop state is handed to the divided-clock domain through a toggle handshake. It takes effect only when the current output period has completed.

Top module: `clkgen_div64`

## Requirements
- R1: Register bits [5:0] hold the divide ratio minus one (field 0 gives ratio 1, field 63 gives ratio 64), and a write is read back unchanged in those bits while the stop bit is clear.
- R2: Register bit 8 is the stop control; while it is 1 the output clock stays low and makes no rising edge.
- R3: The output `cfg_running` is the inverse of register bit 8.
- R4: A write with bit 8 set and bits [5:0] equal to zero stores 0x3F in bits [5:0]; a write with bit 8 set and a non-zero field stores that field unchanged.
- R5: With 4 sources, register bits [7:6] select the source (value n selects `src_clk[n]`), and bits [14:12] are ignored and read as zero.
- R6: With 8 sources, register bits [14:12] select the source (value n selects `src_clk[n]`); every bit other than [14:12], 8 and [5:0] is ignored and reads as zero.
- R7: With a single source there is no select field: bits [7:6] and [14:12] are ignored, read as zero, and `src_clk[0]` always drives the output.
- R8: While running, the output period equals the selected source period times the ratio; ratio 1 passes the selected source clock through, with its own high phase.
- R9: For a ratio r of 2 or more, the output is high for floor(r/2) source periods and low for the rest of the period.
- R10: After reset the register reads 0x0000013F (stopped, field 0x3F, source 0) and the output is low.
- R11: No output high or low pulse is shorter than the high or low phase of a source clock across any divisor, source or stop change; a new divisor applies only at the start of an output period.
- R12: At most one source clock is enabled into the divider at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| cfg_we | input | 1 | Register write strobe, sampled on `clk` |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (implemented fields, others zero) |
| cfg_running | output | 1 | High when the stop bit is clear |
| src_clk | input | NSRC | Source clocks |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
The bench walks the divisor over ratio 1, odd and even ratios and ratio 64, and moves across several sources with distinct periods. For each setting it measures the output period and high time. A design that ignored the plus-one offset, swapped the duty split for odd ratios, or mishandled the ratio-1 pass-through would show the wrong period or high time. The bench also stops the clock with a zero field, which must come back as 0x3F, and writes to select bits that do not exist for a 4-source or single-source build; a decoder that used the wrong field position would report a different source period. A pulse-width monitor runs through every switch of ratio, source and stop, and catches a design that applies a change mid-period or overlaps two source enables, since either leaves a short pulse.

// File: rtl/clkgen_div64_pkg.sv
`timescale 1ns/1ps
package clkgen_div64_pkg;
  localparam int DIV_W    = 6;
  localparam int STOP_BIT = 8;

  // Position of the source-select field for a given source count
  function automatic int sel_lsb(input int nsrc);
    return (nsrc == 8) ? 12 : (nsrc == 4) ? 6 : 0;
  endfunction

  function automatic int sel_width(input int nsrc);
    return (nsrc == 8) ? 3 : (nsrc == 4) ? 2 : 0;
  endfunction

  // Number of divided-clock cycles the output stays high
  function automatic logic [DIV_W-1:0] high_len(input logic [DIV_W-1:0] field);
    logic [DIV_W:0] ratio;
    ratio = {1'b0, field} + 1'b1;
    return ratio[DIV_W:1];
  endfunction

  // A stopped clock may not keep a zero field
  function automatic logic [DIV_W-1:0] stop_fix(input logic stop,
                                                input logic [DIV_W-1:0] field);
    return (stop && field == '0) ? '1 : field;
  endfunction
endpackage

// File: rtl/clkgen_div64_regs.sv
`timescale 1ns/1ps
module clkgen_div64_regs
  import clkgen_div64_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             stop,
  output logic [DIV_W-1:0] div_field,
  output logic [NSRC-1:0]  sel_oh,
  output logic             wr_toggle
);
  localparam int  SEL_LSB = sel_lsb(NSRC);
  localparam int  SEL_W   = sel_width(NSRC);
  localparam bit  HAS_SEL = (SEL_W > 0);
  localparam int  SEL_WE  = HAS_SEL ? SEL_W : 1;

  logic              stop_q;
  logic [DIV_W-1:0]  div_q;
  logic [SEL_WE-1:0] sel_q;
  logic [SEL_WE-1:0] new_sel;
  logic [NSRC-1:0]   oh_nxt;
  logic              tog_q;
  wire               unused_wbits = ^wdata;

  assign new_sel = HAS_SEL ? wdata[SEL_LSB +: SEL_WE] : '0;

  always_comb begin
    for (int i = 0; i < NSRC; i++) oh_nxt[i] = (int'(new_sel) == i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      div_q  <= '1;
      sel_q  <= '0;
      sel_oh <= NSRC'(1);
      tog_q  <= 1'b0;
    end else if (we) begin
      stop_q <= wdata[STOP_BIT];
      div_q  <= stop_fix(wdata[STOP_BIT], wdata[DIV_W-1:0]);
      sel_q  <= new_sel;
      sel_oh <= oh_nxt;
      tog_q  <= ~tog_q;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[DIV_W-1:0] = div_q;
    rdata[STOP_BIT]  = stop_q;
    if (HAS_SEL) rdata[SEL_LSB +: SEL_WE] = sel_q;
  end

  assign stop      = stop_q;
  assign div_field = div_q;
  assign wr_toggle = tog_q;

  AST_STOP_FIELD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (div_q != '0)); // R4
endmodule

// File: rtl/clkgen_div64_srcmux.sv
`timescale 1ns/1ps
module clkgen_div64_srcmux #(
  parameter int NSRC = 8
) (
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_clk,
  input  logic [NSRC-1:0] sel_oh,
  output logic [NSRC-1:0] src_en,
  output logic            mclk
);
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic sync1, en_r;
    wire  others_on = |(src_en & ~(NSRC'(1) << i));
    wire  req       = sel_oh[i] & ~others_on;

    // Enable moves only while this source is low
    always_ff @(negedge src_clk[i] or negedge rst_n) begin
      if (!rst_n) begin
        sync1 <= 1'b0;
        en_r  <= 1'b0;
      end else begin
        sync1 <= req;
        en_r  <= sync1;
      end
    end

    assign src_en[i] = en_r;
    assign gated[i]  = src_clk[i] & en_r;
  end

  assign mclk = |gated;
endmodule

// File: rtl/clkgen_div64_divider.sv
`timescale 1ns/1ps
module clkgen_div64_divider
  import clkgen_div64_pkg::*;
(
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             wr_toggle,
  input  logic             stop,
  input  logic [DIV_W-1:0] div_field,
  output logic             clk_out
);
  logic             t1, t2, t_seen, pend, sh_run, run_act, out_q, byp_q;
  logic [DIV_W-1:0] sh_div, d_act, cnt, nxt_cnt, nxt_d;
  logic             nxt_run;

  wire cap        = t2 ^ t_seen;                   // new setting arrived
  wire wrap       = !run_act || (cnt == d_act);    // output period ends
  wire ratio_load = wrap && pend && !cap;          // setting applied

  always_comb begin
    nxt_d   = ratio_load ? sh_div : d_act;
    nxt_run = ratio_load ? sh_run : run_act;
    nxt_cnt = wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      t1 <= 1'b0; t2 <= 1'b0; t_seen <= 1'b0;
      pend <= 1'b0; sh_run <= 1'b0; sh_div <= '1;
      d_act <= '1; run_act <= 1'b0; cnt <= '0; out_q <= 1'b0;
    end else begin
      t1 <= wr_toggle;
      t2 <= t1;
      if (cap) begin
        t_seen <= t2;
        sh_div <= div_field;
        sh_run <= ~stop;
        pend   <= 1'b1;
      end else if (ratio_load) begin
        pend <= 1'b0;
      end
      d_act   <= nxt_d;
      run_act <= nxt_run;
      cnt     <= nxt_cnt;
      out_q   <= nxt_run && (nxt_cnt < high_len(nxt_d));
    end
  end

  // Pass-through gate changes only while the divided clock is low
  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= run_act && (d_act == '0);
  end

  assign clk_out = out_q | (mclk & byp_q);

  AST_STOPPED_LOW: assert property (@(posedge mclk) disable iff (!rst_n)
    !run_act |-> (!out_q && !byp_q)); // R2
  AST_RATIO_AT_BOUNDARY: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(d_act) |-> (cnt == '0)); // R11
  AST_CNT_IN_RANGE: assert property (@(posedge mclk) disable iff (!rst_n)
    cnt <= d_act); // R9
endmodule

// File: rtl/clkgen_div64.sv
`timescale 1ns/1ps
module clkgen_div64
  import clkgen_div64_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic            cfg_running,
  input  logic [NSRC-1:0] src_clk,
  output logic            clk_out
);
  logic             stop, wr_toggle, mclk;
  logic [DIV_W-1:0] div_field;
  logic [NSRC-1:0]  sel_oh, src_en;

  clkgen_div64_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .stop(stop), .div_field(div_field),
    .sel_oh(sel_oh), .wr_toggle(wr_toggle)
  );

  clkgen_div64_srcmux #(.NSRC(NSRC)) u_mux (
    .rst_n(rst_n), .src_clk(src_clk), .sel_oh(sel_oh),
    .src_en(src_en), .mclk(mclk)
  );

  clkgen_div64_divider u_div (
    .mclk(mclk), .rst_n(rst_n), .wr_toggle(wr_toggle), .stop(stop),
    .div_field(div_field), .clk_out(clk_out)
  );

  assign cfg_running = ~stop;

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_en)); // R12
endmodule

// File: tb/clkgen_div64_test.sv
`timescale 1ns/1ps
module clkgen_div64_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src = '0;
  logic        we8 = 0, we4 = 0, we1 = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rd8, rd4, rd1;
  logic        run8, run4, run1, co8, co4, co1;
  logic [1:0]  mon_sel = 0;
  int          checks = 0, errors = 0;
  longint      rise_cnt = 0;
  realtime     last_edge, min_w = 1.0e9;
  bit          armed = 0;

  always #4 clk = ~clk;
  for (genvar i = 0; i < 8; i++) begin : g_clk
    always #(5 + i) src[i] = ~src[i];  // period 10+2i ns
  end

  clkgen_div64 #(.NSRC(8)) uut (.clk(clk), .rst_n(rst_n), .cfg_we(we8),
    .cfg_wdata(wdata), .cfg_rdata(rd8), .cfg_running(run8),
    .src_clk(src), .clk_out(co8));
  clkgen_div64 #(.NSRC(4)) uut4 (.clk(clk), .rst_n(rst_n), .cfg_we(we4),
    .cfg_wdata(wdata), .cfg_rdata(rd4), .cfg_running(run4),
    .src_clk(src[3:0]), .clk_out(co4));
  clkgen_div64 #(.NSRC(1)) uut1 (.clk(clk), .rst_n(rst_n), .cfg_we(we1),
    .cfg_wdata(wdata), .cfg_rdata(rd1), .cfg_running(run1),
    .src_clk(src[0:0]), .clk_out(co1));

  wire mon = (mon_sel == 0) ? co8 : (mon_sel == 1) ? co4 : co1;

  always @(posedge co8) rise_cnt++;
  always @(co8) if (rst_n) begin  // pulse-width monitor for R11
    if (armed && ($realtime - last_edge) < min_w) min_w = $realtime - last_edge;
    last_edge = $realtime;
    armed = 1;
  end

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [31:0] v);
    @(negedge clk);
    wdata = v;
    if (which == 8) we8 = 1; else if (which == 4) we4 = 1; else we1 = 1;
    @(negedge clk);
    we8 = 0; we4 = 0; we1 = 0;
  endtask

  // Settle, then measure one period and its high phase in ps
  task automatic measure(output longint per_ps, output longint hi_ps);
    realtime t0, t1, t2;
    repeat (4) @(posedge mon);
    t0 = $realtime;
    @(negedge mon); t1 = $realtime;
    @(posedge mon); t2 = $realtime;
    per_ps = longint'((t2 - t0) * 1000.0);
    hi_ps  = longint'((t1 - t0) * 1000.0);
  endtask

  // sel[14:12] and field[5:0]; stop bit clear in every entry
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_0000, 32'h0000_0001, 32'h0000_1002, 32'h0000_3005,
    32'h0000_703F, 32'h0000_2006, 32'h0000_4000, 32'h0000_5009,
    32'h0000_6020 };

  initial begin
    longint per, hi, c0;
    #3 rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (20) @(negedge clk);
    // R10 reset state
    check("R10", "reset readback", rd8, 32'h13F);
    check("R3", "running after reset", run8, 0);
    c0 = rise_cnt;
    #400;
    check("R10", "no edge after reset", rise_cnt - c0, 0);
    check("R10", "output low after reset", co8, 0);

    // Table walk: R1 readback, R8 period, R9 high phase
    mon_sel = 0;
    for (int k = 0; k < NV; k++) begin
      longint p, r, eh;
      wr(8, VEC[k]);
      check("R1", $sformatf("readback vec %0d", k), rd8, VEC[k]);
      p = 10 + 2 * longint'(VEC[k][14:12]);
      r = longint'(VEC[k][5:0]) + 1;
      eh = (r == 1) ? p * 500 : (r / 2) * p * 1000;
      measure(per, hi);
      check("R8", $sformatf("period vec %0d", k), per, p * r * 1000);
      check("R9", $sformatf("high vec %0d", k), hi, eh);
    end

    // Stop with non-zero field, then zero field
    wr(8, 32'h0000_0003);
    measure(per, hi);
    check("R8", "ratio 4 before stop", per, 40000);
    wr(8, 32'h0000_0103);
    check("R4", "stop keeps non-zero field", rd8, 32'h103);
    check("R3", "running while stopped", run8, 0);
    #500;
    c0 = rise_cnt;
    #1000;
    check("R2", "edges while stopped", rise_cnt - c0, 0);
    check("R2", "level while stopped", co8, 0);
    wr(8, 32'h0000_0100);
    check("R4", "stop with zero field", rd8, 32'h13F);
    wr(8, 32'h0000_0000);
    check("R3", "running after restart", run8, 1);
    measure(per, hi);
    check("R8", "pass-through period", per, 10000);
    check("R8", "pass-through high", hi, 5000);

    // R6 unused bits on the 8-source build
    wr(8, 32'hFFFF_FFFF);
    check("R6", "8-source field mask", rd8, 32'h713F);

    // R5 4-source build
    mon_sel = 1;
    wr(4, 32'h0000_0083);
    check("R5", "4-source readback", rd4, 32'h83);
    measure(per, hi);
    check("R5", "4-source period src2", per, 56000);
    wr(4, 32'h0000_2003);
    check("R5", "4-source ignores [14:12]", rd4, 32'h003);
    measure(per, hi);
    check("R5", "4-source period src0", per, 40000);

    // R7 single-source build
    mon_sel = 2;
    wr(1, 32'h0000_70C1);
    check("R7", "1-source readback", rd1, 32'h001);
    measure(per, hi);
    check("R7", "1-source period", per, 20000);

    // R11 no runt pulse across every change above
    check("R11", "min pulse width ps", (min_w >= 5.0) ? 1 : 0, 1);
    if (min_w < 5.0) $display("  min width %0t", min_w);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule